// File: doc/BRIEF.md
# I2C Byte Transfer Engine with Deferred Acknowledge

This block is the per-byte data path of an I2C controller, placed behind an 8-bit data register. Software access to that register starts a transfer as a side effect. A write starts a transmit, and a read starts a receive. Each access starts a transfer only when the direction control agrees with it. The engine shifts one bit per SCL bit slot, most significant bit first. A separate bit-timing unit marks each bit slot with a one-cycle `slot_tick` pulse. The engine samples `sda_in` on that pulse and moves to the next bit.

In transmit, the engine records the acknowledge that the far end returns. In receive, it drives the acknowledge from a software-owned transmit-acknowledge bit. A deferred-acknowledge option stops the engine after the eighth data bit and holds SCL low. The engine stays there until software writes its ACK/NACK choice. The same triggers serve master data phases and, after an address match, slave data phases. Two strobes feed the interrupt flag logic: byte-done and after-acknowledge.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, the data register reads 0x00, `busy` is 0, `sda_drive_low` and `scl_hold_low` are 0, and `rx_ack` is 0.
- R2: A write access while idle, with `role_tx`=1 and the engine active, loads the written byte and starts a transmit. From the next cycle, `sda_drive_low` is the inverse of the current bit, starting with bit 7. The engine moves to the next lower bit on each `slot_tick`.
- R3: After the eighth transmitted bit, the engine releases SDA for one acknowledge slot. On that slot's tick it stores `sda_in` in `rx_ack` (0 = acknowledged, 1 = not acknowledged). In the following cycle it pulses `byte_done` and `ack_done` for one cycle and returns idle.
- R4: A read access while idle, with `role_tx`=0 and the engine active, starts a receive. The engine samples `sda_in` on eight ticks, MSB first. The data register takes the assembled byte on the eighth tick. `rd_data` returns the last byte received.
- R5: A read access with `role_tx`=1 does not start a transfer, and a write access with `role_tx`=0 does not start one either.
- R6: The engine is active when `is_master`=1, or when `is_master`=0 and `addr_hit`=1. While it is inactive, register accesses start nothing.
- R7: With deferred acknowledge off at receive start, the slot after the eighth bit drives the stored acknowledge bit. `sda_drive_low` is 1 for ACK (bit 0) and 0 for NACK (bit 1). Both strobes pulse in the cycle after that slot's tick.
- R8: With deferred acknowledge on at receive start, `byte_done` pulses in the cycle after the eighth tick. The engine then holds `scl_hold_low`=1 with SDA released and ignores ticks until a transmit-acknowledge write arrives. After that write it drives the written value for one slot, then pulses only `ack_done`.
- R9: Transmitted bytes never appear in the data register.
- R10: Register accesses while `busy`=1 start nothing and do not alter the byte in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 = master role |
| addr_hit | input | 1 | Slave address matched (used when not master) |
| role_tx | input | 1 | Direction control: 1 = transmit, 0 = receive |
| fast_ack_en | input | 1 | Deferred acknowledge enable, latched at receive start |
| reg_wr_en | input | 1 | Data register write access strobe |
| reg_wr_data | input | 8 | Data register write value |
| reg_rd_en | input | 1 | Data register read access strobe |
| txack_wr_en | input | 1 | Write strobe for the transmit-acknowledge bit |
| txack_val | input | 1 | Transmit-acknowledge value (0 = ACK, 1 = NACK) |
| slot_tick | input | 1 | One pulse per SCL bit slot from the bit-timing unit |
| sda_in | input | 1 | Sampled SDA line level |
| rd_data | output | 8 | Data register read value (last received byte) |
| sda_drive_low | output | 1 | Open-drain SDA pull-down request |
| scl_hold_low | output | 1 | SCL stretch request during the deferred acknowledge hold |
| busy | output | 1 | A byte transfer is in progress |
| rx_ack | output | 1 | Acknowledge seen after the last transmitted byte |
| byte_done | output | 1 | One-cycle byte completion strobe |
| ack_done | output | 1 | One-cycle strobe after the acknowledge slot |

## Verification
The hardest state to reach is the deferred acknowledge hold. The stimulus must start a receive with deferred acknowledge enabled and deliver all eight ticks. It must then send extra ticks while the engine is parked, and show that SCL stays stretched and the bit count does not move. It must also choose both ACK and NACK values for the late write. The stimulus makes illegal accesses mid-byte: writes during a transmit and reads during a receive. A behavioural model compares the pin pattern every cycle, so a corrupted byte in flight shows up directly.

// File: rtl/i2c_bytx_pkg.sv
package i2c_bytx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_TX_BITS = 3'd1,
        PH_TX_ACK  = 3'd2,
        PH_RX_BITS = 3'd3,
        PH_RX_HOLD = 3'd4,
        PH_RX_ACK  = 3'd5
    } phase_e;

endpackage

// File: rtl/i2c_bytx_shifter.sv
module i2c_bytx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] word,
    output logic         last
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  word;
        logic [CW-1:0] cnt;
    } sh_state_t;

    sh_state_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.word = load_val;
            d.cnt  = '0;
        end else if (shift) begin
            d.word = {q.word[W-2:0], ser_in};
            d.cnt  = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word = q.word;
    assign last = (q.cnt == CW'(W - 1));

    // R2 / R4: each shift pulls the serial input into the low bit
    a_r2_shift_in_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (q.word[0] == $past(ser_in)));

endmodule

// File: rtl/i2c_bytx_ctrl.sv
module i2c_bytx_ctrl
    import i2c_bytx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_tx,
    input  logic         start_rx,
    input  logic [W-1:0] wr_byte,
    input  logic         fast_ack_en,
    input  logic         txack_wr_en,
    input  logic         txack_val,
    input  logic         slot_tick,
    input  logic         sda_in,
    input  logic [W-1:0] sh_word,
    input  logic         sh_last,
    output logic         sh_load,
    output logic [W-1:0] sh_load_val,
    output logic         sh_shift,
    output logic [W-1:0] data_out,
    output logic         sda_drive_low,
    output logic         scl_hold_low,
    output logic         busy,
    output logic         rx_ack,
    output logic         byte_done,
    output logic         ack_done
);
    typedef struct packed {
        phase_e       phase;
        logic [W-1:0] data;
        logic         rx_ack;
        logic         tx_ack;
        logic         fast;
        logic         byte_done;
        logic         ack_done;
    } ctl_state_t;

    ctl_state_t q, d;

    always_comb begin
        d             = q;
        d.byte_done   = 1'b0;
        d.ack_done    = 1'b0;
        sh_load       = 1'b0;
        sh_load_val   = '0;
        sh_shift      = 1'b0;
        if (txack_wr_en) d.tx_ack = txack_val;
        unique case (q.phase)
            PH_IDLE: begin
                if (start_tx) begin
                    sh_load     = 1'b1;
                    sh_load_val = wr_byte;
                    d.phase     = PH_TX_BITS;
                end else if (start_rx) begin
                    sh_load     = 1'b1;
                    d.fast      = fast_ack_en;
                    d.phase     = PH_RX_BITS;
                end
            end
            PH_TX_BITS: begin
                if (slot_tick) begin
                    sh_shift = 1'b1;
                    if (sh_last) d.phase = PH_TX_ACK;
                end
            end
            PH_TX_ACK: begin
                if (slot_tick) begin
                    d.rx_ack    = sda_in;
                    d.byte_done = 1'b1;
                    d.ack_done  = 1'b1;
                    d.phase     = PH_IDLE;
                end
            end
            PH_RX_BITS: begin
                if (slot_tick) begin
                    sh_shift = 1'b1;
                    if (sh_last) begin
                        d.data = {sh_word[W-2:0], sda_in};
                        if (q.fast) begin
                            d.byte_done = 1'b1;
                            d.phase     = PH_RX_HOLD;
                        end else begin
                            d.phase     = PH_RX_ACK;
                        end
                    end
                end
            end
            PH_RX_HOLD: begin
                if (txack_wr_en) d.phase = PH_RX_ACK;
            end
            PH_RX_ACK: begin
                if (slot_tick) begin
                    d.ack_done  = 1'b1;
                    d.byte_done = !q.fast;
                    d.phase     = PH_IDLE;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign data_out      = q.data;
    assign rx_ack        = q.rx_ack;
    assign byte_done     = q.byte_done;
    assign ack_done      = q.ack_done;
    assign busy          = (q.phase != PH_IDLE);
    assign scl_hold_low  = (q.phase == PH_RX_HOLD);
    assign sda_drive_low = ((q.phase == PH_TX_BITS) && !sh_word[W-1]) ||
                           ((q.phase == PH_RX_ACK)  && !q.tx_ack);

    // R8: the stretch persists until software supplies the acknowledge choice
    a_r8_hold_until_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RX_HOLD && !txack_wr_en) |=> (q.phase == PH_RX_HOLD));

    // R9: the data register changes only as a result of receiving
    a_r9_data_from_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.data) |-> $past(q.phase == PH_RX_BITS));

    // R3: the received acknowledge is captured only in the transmit ack slot
    a_r3_rxack_from_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.rx_ack) |-> $past(q.phase == PH_TX_ACK));

    // R7: completion strobes arrive only when idle or parked for a decision
    a_r7_done_phase: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (q.phase == PH_IDLE || q.phase == PH_RX_HOLD));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              addr_hit,
    input  logic              role_tx,
    input  logic              fast_ack_en,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              reg_rd_en,
    input  logic              txack_wr_en,
    input  logic              txack_val,
    input  logic              slot_tick,
    input  logic              sda_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              sda_drive_low,
    output logic              scl_hold_low,
    output logic              busy,
    output logic              rx_ack,
    output logic              byte_done,
    output logic              ack_done
);
    logic              engine_active;
    logic              start_tx, start_rx;
    logic              sh_load, sh_shift, sh_last;
    logic [DATA_W-1:0] sh_load_val, sh_word;

    assign engine_active = is_master || addr_hit;
    assign start_tx      = reg_wr_en &&  role_tx && engine_active;
    assign start_rx      = reg_rd_en && !role_tx && engine_active;

    i2c_bytx_shifter #(.W(DATA_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_load_val),
        .shift    (sh_shift),
        .ser_in   (sda_in),
        .word     (sh_word),
        .last     (sh_last)
    );

    i2c_bytx_ctrl #(.W(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_tx      (start_tx),
        .start_rx      (start_rx),
        .wr_byte       (reg_wr_data),
        .fast_ack_en   (fast_ack_en),
        .txack_wr_en   (txack_wr_en),
        .txack_val     (txack_val),
        .slot_tick     (slot_tick),
        .sda_in        (sda_in),
        .sh_word       (sh_word),
        .sh_last       (sh_last),
        .sh_load       (sh_load),
        .sh_load_val   (sh_load_val),
        .sh_shift      (sh_shift),
        .data_out      (rd_data),
        .sda_drive_low (sda_drive_low),
        .scl_hold_low  (scl_hold_low),
        .busy          (busy),
        .rx_ack        (rx_ack),
        .byte_done     (byte_done),
        .ack_done      (ack_done)
    );

    // R5: a read while the direction says transmit leaves the engine idle
    a_r5_read_in_tx_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_rd_en && role_tx && !reg_wr_en) |=> !busy);

    // R6: an unmatched slave never starts a transfer
    a_r6_slave_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !is_master && !addr_hit) |=> !busy);

endmodule

// File: tb/i2c_byte_engine_bench.sv
`timescale 1ns/1ps
module i2c_byte_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b1, addr_hit = 1'b0, role_tx = 1'b1, fast_ack_en = 1'b0;
    logic       reg_wr_en = 1'b0, reg_rd_en = 1'b0, txack_wr_en = 1'b0, txack_val = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic       slot_tick = 1'b0, sda_in = 1'b1;
    logic [7:0] rd_data;
    logic       sda_drive_low, scl_hold_low, busy, rx_ack, byte_done, ack_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic last_bd, last_ad;

    always #2 clk = ~clk;

    i2c_byte_engine u_i2c_byte_engine (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .addr_hit(addr_hit),
        .role_tx(role_tx), .fast_ack_en(fast_ack_en), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .txack_wr_en(txack_wr_en),
        .txack_val(txack_val), .slot_tick(slot_tick), .sda_in(sda_in),
        .rd_data(rd_data), .sda_drive_low(sda_drive_low), .scl_hold_low(scl_hold_low),
        .busy(busy), .rx_ack(rx_ack), .byte_done(byte_done), .ack_done(ack_done)
    );

    // ---------------- behavioural reference ----------------
    // step: 0 idle, 1 sending bits, 2 awaiting ack, 3 collecting bits, 4 parked, 5 giving ack
    int         step;
    bit         out_bits[$];
    bit         in_bits[$];
    logic [7:0] m_data;
    logic       m_rxack, m_txack, m_fast, m_bd, m_ad;

    always @(posedge clk) begin
        if (!rst_n) begin
            step = 0; out_bits.delete(); in_bits.delete();
            m_data = 8'h00; m_rxack = 1'b0; m_txack = 1'b0; m_fast = 1'b0;
            m_bd = 1'b0; m_ad = 1'b0;
        end else begin
            m_bd = 1'b0; m_ad = 1'b0;
            case (step)
                0: begin
                    if ((is_master || addr_hit) && reg_wr_en && role_tx) begin
                        out_bits.delete();
                        for (int k = 7; k >= 0; k--) out_bits.push_back(reg_wr_data[k]);
                        step = 1;
                    end else if ((is_master || addr_hit) && reg_rd_en && !role_tx) begin
                        in_bits.delete();
                        m_fast = fast_ack_en;
                        step = 3;
                    end
                end
                1: if (slot_tick) begin
                    void'(out_bits.pop_front());
                    if (out_bits.size() == 0) step = 2;
                end
                2: if (slot_tick) begin
                    m_rxack = sda_in; m_bd = 1'b1; m_ad = 1'b1; step = 0;
                end
                3: if (slot_tick) begin
                    in_bits.push_back(sda_in);
                    if (in_bits.size() == 8) begin
                        for (int k = 0; k < 8; k++) m_data[7-k] = in_bits[k];
                        if (m_fast) begin m_bd = 1'b1; step = 4; end
                        else step = 5;
                    end
                end
                4: if (txack_wr_en) step = 5;
                5: if (slot_tick) begin
                    m_ad = 1'b1; m_bd = !m_fast; step = 0;
                end
                default: step = 0;
            endcase
            if (txack_wr_en) m_txack = txack_val;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic e_sda;
            e_sda = (step == 1 && out_bits.size() > 0) ? !out_bits[0] :
                    (step == 5) ? !m_txack : 1'b0;
            check(sda_drive_low == e_sda, "R2", "model sda_drive_low", sda_drive_low, e_sda);
            check(scl_hold_low == (step == 4), "R8", "model scl_hold_low", scl_hold_low, step == 4);
            check(busy == (step != 0), "R10", "model busy", busy, step != 0);
            check(rd_data == m_data, "R4", "model rd_data", rd_data, m_data);
            check(rx_ack == m_rxack, "R3", "model rx_ack", rx_ack, m_rxack);
            check(byte_done == m_bd, "R7", "model byte_done", byte_done, m_bd);
            check(ack_done == m_ad, "R8", "model ack_done", ack_done, m_ad);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_write(input logic [7:0] v);
        reg_wr_data = v; reg_wr_en = 1'b1;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic do_read();
        reg_rd_en = 1'b1;
        @(negedge clk); reg_rd_en = 1'b0;
    endtask

    task automatic set_txack(input logic v);
        txack_val = v; txack_wr_en = 1'b1;
        @(negedge clk); txack_wr_en = 1'b0;
    endtask

    task automatic tick(input logic b);
        sda_in = b; slot_tick = 1'b1;
        @(negedge clk); slot_tick = 1'b0;
        last_bd = byte_done; last_ad = ack_done;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic far_ack, input logic poke);
        do_write(v);
        for (int i = 7; i >= 0; i--) begin
            check(sda_drive_low == !v[i], "R2", "tx bit level", sda_drive_low, !v[i]);
            if (poke && i == 4) begin
                do_write(~v);   // R10: ignored while busy
                do_read();
            end
            tick(1'b1);
        end
        check(sda_drive_low == 1'b0, "R3", "ack slot released", sda_drive_low, 0);
        tick(far_ack);
        check(last_bd && last_ad, "R3", "tx strobes", {last_bd, last_ad}, 3);
        check(rx_ack == far_ack, "R3", "rx_ack value", rx_ack, far_ack);
        check(!busy, "R3", "idle after tx", busy, 0);
    endtask

    task automatic recv_byte(input logic [7:0] v, input logic fast, input logic ackv,
                             input logic poke);
        fast_ack_en = fast;
        if (!fast) set_txack(ackv);
        do_read();
        for (int i = 7; i >= 0; i--) begin
            if (poke && i == 3) begin
                do_read();      // R10: ignored while busy
                do_write(8'hFF);
            end
            tick(v[i]);
        end
        if (fast) begin
            check(last_bd, "R8", "early byte_done", last_bd, 1);
            check(scl_hold_low, "R8", "scl held", scl_hold_low, 1);
            check(sda_drive_low == 1'b0, "R8", "sda released in hold", sda_drive_low, 0);
            tick(1'b0);
            check(scl_hold_low && busy, "R8", "tick ignored in hold", scl_hold_low, 1);
            set_txack(ackv);
            check(sda_drive_low == !ackv, "R8", "deferred ack level", sda_drive_low, !ackv);
        end else begin
            check(sda_drive_low == !ackv, "R7", "ack level", sda_drive_low, !ackv);
        end
        tick(1'b1);
        check(last_ad, "R7", "ack_done", last_ad, 1);
        check(last_bd == !fast, "R7", "byte_done after ack", last_bd, !fast);
        check(rd_data == v, "R4", "received byte", rd_data, v);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 8'h00, "R1", "reset data", rd_data, 0);
        check(!busy && !sda_drive_low && !scl_hold_low && !rx_ack, "R1", "reset outputs",
              {busy, sda_drive_low, scl_hold_low, rx_ack}, 0);

        // master transmit: acknowledged, then not acknowledged with mid-byte pokes
        role_tx = 1'b1;
        send_byte(8'hA5, 1'b0, 1'b0);
        send_byte(8'h3C, 1'b1, 1'b1);
        check(rd_data == 8'h00, "R9", "tx not visible", rd_data, 0);

        // wrong-direction accesses
        do_read();
        check(!busy, "R5", "read in tx dir", busy, 0);
        role_tx = 1'b0;
        do_write(8'h77);
        check(!busy, "R5", "write in rx dir", busy, 0);

        // master receive, normal ack then nack, one with pokes
        recv_byte(8'h96, 1'b0, 1'b0, 1'b1);
        recv_byte(8'h01, 1'b0, 1'b1, 1'b0);

        // deferred acknowledge: ACK and NACK choices
        recv_byte(8'h5A, 1'b1, 1'b0, 1'b0);
        recv_byte(8'hE7, 1'b1, 1'b1, 1'b1);
        fast_ack_en = 1'b0;

        // transmit after receive leaves received byte in place
        role_tx = 1'b1;
        send_byte(8'h0F, 1'b0, 1'b0);
        check(rd_data == 8'hE7, "R9", "last rx kept", rd_data, 8'hE7);

        // slave without match: no start; with match: transfers run
        is_master = 1'b0; addr_hit = 1'b0;
        do_write(8'h44);
        check(!busy, "R6", "unmatched write", busy, 0);
        role_tx = 1'b0;
        do_read();
        check(!busy, "R6", "unmatched read", busy, 0);
        addr_hit = 1'b1;
        recv_byte(8'hC3, 1'b0, 1'b0, 1'b0);
        role_tx = 1'b1;
        do_write(8'h81);
        check(busy, "R6", "matched slave starts", busy, 1);
        for (int i = 7; i >= 0; i--) tick(1'b1);
        tick(1'b0);
        check(rx_ack == 1'b0 && !busy, "R6", "slave tx finished", rx_ack, 0);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule